// File: doc/BRIEF.md
# Wake and SMI event status controller

This block watches a small set of general-purpose input pins and records qualifying edges as sticky status bits. Each pin passes through a two-flop synchroniser, then an edge detector whose direction is chosen per pin by a polarity bit. A detected edge sets the pin's bit in a wake status register and, for pins routed to it, in an SMI status register.

Two active-low outputs come from masking these status bits. The wake output needs both the per-bit wake enable and a single global wake enable. The SMI output needs only the per-bit SMI enable. Parameters choose which pins feed each path. By default all three pins feed the wake path and only pins 0 and 1 feed the SMI path.

Software reaches the block through a simple register port. Status bits clear when 1 is written to them. Reads are combinational.

Top module: `wake_smi_ctrl`

## Requirements
- R1: While reset is low, and after it is released, every register reads 0 and both `wake_n` and `smi_n` are high.
- R2: Each pin passes through a two-flop synchroniser. A qualifying edge applied before clock edge k sets the pin's status bit at clock edge k+2. The bit is not yet set after edge k+1.
- R3: Bit i of the polarity register (address 5) selects the active edge of pin i: 0 means rising and 1 means falling. An edge in the other direction leaves every status bit unchanged.
- R4: `wake_n` is low exactly when bit 0 of the global register (address 0) is 1 and the AND of the wake status (address 1) and wake enable (address 2) is nonzero.
- R5: `smi_n` is low exactly when the AND of the SMI status (address 3) and SMI enable (address 4) is nonzero. The global wake enable has no effect on it.
- R6: Pin 2 feeds only the wake path. Its edges never set bit 2 of the SMI status register.
- R7: Writing 1 to a bit of either status register clears that bit. Writing 0 leaves it unchanged. An output driven only by that bit goes high at the same clock edge that performs the clear.
- R8: If a new event on a pin and a clear of its status bit fall on the same clock edge, the bit stays set.
- R9: Pin i maps to bit i in every register. Enable bits of pins that do not feed a path read 0. Bits above the pin count, and unmapped addresses (6 and 7), read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 3 | Asynchronous event input pins |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| wake_n | output | 1 | Active-low wake request |
| smi_n | output | 1 | Active-low SMI request |

## Verification
The hardest situation to reach is a status clear landing on exactly the clock edge where a new event leaves the synchroniser. From the ports, this means counting the synchroniser stages so that the write strobe is raised one half-cycle before the third clock edge after the pin toggles. The bench does this for pin 0 after first setting the bit, so a lost event would show up as a cleared bit. The output masking is swept over every combination of global enable, wake enable and SMI enable, for each pin under each polarity.

// File: rtl/wake_smi_ctrl.sv
module wake_smi_ctrl #(
  parameter int NPIN = 3,
  parameter int DW = 8,
  parameter int AW = 3,
  parameter logic [NPIN-1:0] WAKE_SRC = '1,
  parameter logic [NPIN-1:0] SMI_SRC = 3'b011
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_we,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            wake_n,
  output logic            smi_n
);
  localparam logic [AW-1:0] A_GLB  = AW'(0);
  localparam logic [AW-1:0] A_WSTS = AW'(1);
  localparam logic [AW-1:0] A_WEN  = AW'(2);
  localparam logic [AW-1:0] A_SSTS = AW'(3);
  localparam logic [AW-1:0] A_SEN  = AW'(4);
  localparam logic [AW-1:0] A_POL  = AW'(5);

  logic [NPIN-1:0] sync1, sync2, last, ev;
  logic [NPIN-1:0] pol, wsts, wen, ssts, sen;
  logic            glb;

  wire [NPIN-1:0] wd = reg_wdata[NPIN-1:0];
  wire wr_glb  = reg_we && reg_addr == A_GLB;
  wire wr_wsts = reg_we && reg_addr == A_WSTS;
  wire wr_wen  = reg_we && reg_addr == A_WEN;
  wire wr_ssts = reg_we && reg_addr == A_SSTS;
  wire wr_sen  = reg_we && reg_addr == A_SEN;
  wire wr_pol  = reg_we && reg_addr == A_POL;

  assign ev = (sync2 ^ last) & (sync2 ^ pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      last  <= '0;
      pol   <= '0;
      wsts  <= '0;
      wen   <= '0;
      ssts  <= '0;
      sen   <= '0;
      glb   <= 1'b0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      last  <= sync2;
      if (wr_glb) glb <= reg_wdata[0];
      if (wr_pol) pol <= wd;
      if (wr_wen) wen <= wd & WAKE_SRC;
      if (wr_sen) sen <= wd & SMI_SRC;
      wsts <= (wsts & ~(wr_wsts ? wd : '0)) | (ev & WAKE_SRC);
      ssts <= (ssts & ~(wr_ssts ? wd : '0)) | (ev & SMI_SRC);
    end
  end

  always_comb begin
    case (reg_addr)
      A_GLB:   reg_rdata = DW'(glb);
      A_WSTS:  reg_rdata = DW'(wsts);
      A_WEN:   reg_rdata = DW'(wen);
      A_SSTS:  reg_rdata = DW'(ssts);
      A_SEN:   reg_rdata = DW'(sen);
      A_POL:   reg_rdata = DW'(pol);
      default: reg_rdata = '0;
    endcase
  end

  assign wake_n = ~(glb & |(wsts & wen));
  assign smi_n  = ~|(ssts & sen);
endmodule

module wake_smi_chk #(
  parameter int NPIN = 3,
  parameter int AW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   reg_addr,
  input logic            reg_we,
  input logic [NPIN-1:0] ev,
  input logic [NPIN-1:0] wsts,
  input logic [NPIN-1:0] ssts,
  input logic            glb,
  input logic            wake_n,
  input logic            smi_n
);
  assert_wake_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(wsts) & ~wsts)) |-> $past(reg_we && reg_addr == AW'(1)));

  assert_smi_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(ssts) & ~ssts)) |-> $past(reg_we && reg_addr == AW'(3)));

  assert_set_needs_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(wsts & ~$past(wsts))) |-> $past(|ev));

  assert_global_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !glb |-> wake_n);

  assert_smi_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ssts == '0) |-> smi_n);
endmodule

bind wake_smi_ctrl wake_smi_chk #(.NPIN(NPIN), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .ev(ev),
  .wsts(wsts), .ssts(ssts), .glb(glb), .wake_n(wake_n), .smi_n(smi_n));

// File: tb/wake_smi_ctrl_test.sv
`timescale 1ns/1ps
module wake_smi_ctrl_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic [2:0] pins;
  logic [2:0] addr;
  logic       we;
  logic [7:0] wdata;
  wire  [7:0] rdata;
  wire        wake_n, smi_n;
  int checks = 0, errors = 0;

  wake_smi_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .reg_addr(addr), .reg_we(we),
    .reg_wdata(wdata), .reg_rdata(rdata), .wake_n(wake_n), .smi_n(smi_n));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [2:0] exp_w, exp_s;
    rst_n = 1'b0; pins = '0; addr = '0; we = 1'b0; wdata = '0;
    idle(3);
    check("R1 wake_n in reset", wake_n, 1);
    check("R1 smi_n in reset", smi_n, 1);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 register after reset", d, 0);
    end
    check("R1 wake_n after reset", wake_n, 1);
    check("R1 smi_n after reset", smi_n, 1);

    wr(0, 8'hFF); rd(0, d); check("R9 global reads bit0 only", d, 8'h01);
    wr(2, 8'hFF); rd(2, d); check("R9 wake enable width", d, 8'h07);
    wr(4, 8'hFF); rd(4, d); check("R9 smi enable pin2 reads 0", d, 8'h03);
    wr(5, 8'hFF); rd(5, d); check("R9 polarity width", d, 8'h07);
    wr(6, 8'hFF); rd(6, d); check("R9 unmapped reads 0", d, 8'h00);
    wr(0, 0); wr(2, 0); wr(4, 0); wr(5, 0);

    for (int p = 0; p < 3; p++) begin
      for (int pol = 0; pol < 2; pol++) begin
        wr(5, 8'(pol << p));
        pins[p] = pol[0];
        idle(4);
        rd(1, d); check("R3 inactive edge ignored (wake)", d, 0);
        rd(3, d); check("R3 inactive edge ignored (smi)", d, 0);
        addr = 3'd1;
        pins[p] = ~pol[0];
        @(negedge clk); @(negedge clk); #1;
        check("R2 not set after one synchroniser edge", rdata, 0);
        @(negedge clk); #1;
        exp_w = 3'(1 << p);
        exp_s = exp_w & 3'b011;
        check("R2 R3 wake status set on active edge", rdata, 32'(exp_w));
        addr = 3'd3; #1;
        check("R6 smi status by source", rdata, 32'(exp_s));
        pins[p] = pol[0];
        idle(4);
        rd(1, d); check("R3 opposite edge leaves wake status", d, 32'(exp_w));
        rd(3, d); check("R3 opposite edge leaves smi status", d, 32'(exp_s));
        for (int g = 0; g < 2; g++)
          for (int e = 0; e < 8; e++)
            for (int s = 0; s < 4; s++) begin
              wr(0, 8'(g)); wr(2, 8'(e)); wr(4, 8'(s));
              check("R4 wake_n masking", wake_n, !(g == 1 && (exp_w & 3'(e)) != 0));
              check("R5 smi_n masking", smi_n, (exp_s & 3'(s)) == 0);
            end
        wr(0, 1); wr(2, 7); wr(4, 3);
        wr(1, 8'(~exp_w & 3'b111));
        rd(1, d); check("R7 writing 0 keeps wake bit", d, 32'(exp_w));
        check("R7 wake_n still low", wake_n, 0);
        wr(1, 8'(exp_w));
        check("R7 wake_n high at clearing edge", wake_n, 1);
        rd(1, d); check("R7 wake bit cleared", d, 0);
        wr(3, 8'(exp_s));
        check("R7 smi_n high after clear", smi_n, 1);
        rd(3, d); check("R7 smi bit cleared", d, 0);
        wr(0, 0); wr(2, 0); wr(4, 0); wr(5, 0);
        pins[p] = 1'b0;
        idle(4);
        rd(1, d); check("R3 falling with rising polarity ignored", d, 0);
      end
    end

    @(negedge clk); pins[0] = 1'b1; idle(4);
    pins[0] = 1'b0; idle(4);
    rd(1, d); check("R8 setup bit set", d, 1);
    @(negedge clk); pins[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    addr = 3'd1; wdata = 8'h01; we = 1'b1;
    @(negedge clk); we = 1'b0; #1;
    check("R8 event beats same-edge clear", rdata, 1);
    wr(1, 8'h01); rd(1, d); check("R7 later clear succeeds", d, 0);
    wr(3, 8'h01); rd(3, d); check("R7 smi clear", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule